// File: doc/BRIEF.md
# Indexed CMOS RAM Port with NMI Mask

This block gives a host processor access to a 128-byte real-time-clock standard RAM bank through two I/O ports. The index port is write-only. Each byte written there does two things at once. Its low seven bits select a RAM location, and its top bit is a mask that gates the incoming NMI request before it leaves the block.

The data port reads or writes the RAM byte that the latched index selects. The index never advances by itself, so every access to the data port hits the same byte until software writes the index port again. Because the mask and the index share one byte, software must supply the intended mask value on every index write.

The host side is a simple synchronous I/O bus. It has an address, a write strobe, a read strobe, write data and registered read data. Reads of the index port or of any unclaimed address return all ones and change nothing.

Top module: `cmos_ram_port`

## Requirements
- R1: After reset, the NMI mask is set, so nmi_o is 0 whatever nmi_req_i is. io_rdata_o reads 0xFF.
- R2: A write to I/O address 0x70 loads write-data bits 6:0 as the RAM index and bit 7 as the NMI mask, both on the same clock edge.
- R3: nmi_o equals nmi_req_i AND NOT mask, where a mask of 1 blocks and 0 passes. A change of mask shows on nmi_o after the edge that samples the index write.
- R4: A write to I/O address 0x71 stores the write data into the RAM byte at the latched index on the edge that samples the strobe.
- R5: A read of 0x71 puts the RAM byte at the latched index on io_rdata_o after the edge that samples the read strobe. io_rdata_o then holds until the next read strobe, even across writes.
- R6: The index does not auto-increment: repeated reads and writes of 0x71 all address the same byte.
- R7: A read of 0x70 returns 0xFF and leaves the index, the mask and the RAM unchanged.
- R8: Writes to any address other than 0x70 and 0x71 change no state. Reads of such addresses return 0xFF.
- R9: Bit 7 of an index write does not take part in RAM addressing. Bits 6:0 do not take part in NMI gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | I/O address of the current access |
| io_wr_i | input | 1 | Write strobe, one cycle per write |
| io_rd_i | input | 1 | Read strobe, one cycle per read |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Registered read data |
| nmi_req_i | input | 1 | Incoming NMI request |
| nmi_o | output | 1 | NMI request after the mask is applied |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that software writes a RAM byte before it reads that byte, since the RAM has no reset value. The bench drives each strobe from its own task, one access at a time, so the two strobes can never overlap. Before any random or directed reads, the bench fills all 128 bytes through the normal index and data sequence. Every later read therefore compares against a known model value.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_INDEX = 2'd1,
    SEL_DATA  = 2'd2
  } io_sel_e;
endpackage

// File: rtl/cmos_decode.sv
module cmos_decode
  import cmos_pkg::*;
#(
  parameter int          IO_AW      = 16,
  parameter logic [15:0] INDEX_ADDR = 16'h0070,
  parameter logic [15:0] DATA_ADDR  = 16'h0071
) (
  input  logic [IO_AW-1:0] addr_i,
  output io_sel_e          sel_o
);
  always_comb begin
    if (addr_i == INDEX_ADDR[IO_AW-1:0])     sel_o = SEL_INDEX;
    else if (addr_i == DATA_ADDR[IO_AW-1:0]) sel_o = SEL_DATA;
    else                                     sel_o = SEL_NONE;
  end
endmodule

// File: rtl/cmos_index_reg.sv
module cmos_index_reg #(
  parameter int RAM_AW = 7,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [RAM_AW-1:0] idx_o,
  output logic              mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      mask_o <= 1'b1;
    end else if (load_i) begin
      idx_o  <= wdata_i[RAM_AW-1:0];
      mask_o <= wdata_i[DW-1];
    end
  end

  // R2
  idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (idx_o == $past(wdata_i[RAM_AW-1:0])) && (mask_o == $past(wdata_i[DW-1])));

  // R7 R8
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(idx_o) && $stable(mask_o));
endmodule

// File: rtl/cmos_ram.sv
module cmos_ram #(
  parameter int RAM_AW = 7,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [RAM_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [DW-1:0] mem_q [DEPTH];

  // no reset on storage: contents are undefined at power-up
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) rdata_o <= mem_q[addr_i];
  end

  // R4
  ram_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/cmos_ram_port.sv
module cmos_ram_port
  import cmos_pkg::*;
#(
  parameter int          IO_AW      = 16,
  parameter int          RAM_AW     = 7,
  parameter int          DW         = 8,
  parameter logic [15:0] INDEX_ADDR = 16'h0070,
  parameter logic [15:0] DATA_ADDR  = 16'h0071
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             io_wr_i,
  input  logic             io_rd_i,
  input  logic [DW-1:0]    io_wdata_i,
  output logic [DW-1:0]    io_rdata_o,
  input  logic             nmi_req_i,
  output logic             nmi_o
);
  localparam logic [DW-1:0] IDLE_BYTE = '1;

  io_sel_e           sel;
  logic [RAM_AW-1:0] idx;
  logic              mask;
  logic [DW-1:0]     ram_rdata;
  logic              data_sel_q;

  cmos_decode #(
    .IO_AW(IO_AW), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_decode (
    .addr_i(io_addr_i),
    .sel_o (sel)
  );

  cmos_index_reg #(.RAM_AW(RAM_AW), .DW(DW)) u_index (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (io_wr_i && sel == SEL_INDEX),
    .wdata_i(io_wdata_i),
    .idx_o  (idx),
    .mask_o (mask)
  );

  cmos_ram #(.RAM_AW(RAM_AW), .DW(DW)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(io_wr_i && sel == SEL_DATA),
    .rd_en_i(io_rd_i && sel == SEL_DATA),
    .addr_i (idx),
    .wdata_i(io_wdata_i),
    .rdata_o(ram_rdata)
  );

  // remembers whether the last read hit the data port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_sel_q <= 1'b0;
    else if (io_rd_i) data_sel_q <= (sel == SEL_DATA);
  end

  assign io_rdata_o = data_sel_q ? ram_rdata : IDLE_BYTE;
  assign nmi_o      = nmi_req_i & ~mask;

  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_rd_i && io_wr_i));

  // R5
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |=> $stable(io_rdata_o));

  // R7 R8
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && sel != SEL_DATA) |=> io_rdata_o == IDLE_BYTE);

  // R3
  nmi_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask |-> !nmi_o);

  // R3
  nmi_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> nmi_req_i);
endmodule

// File: tb/cmos_ram_port_tb.sv
module cmos_ram_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        nmi_req = 1'b0;
  logic        nmi;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] model_ram [128];
  logic [6:0] model_idx;
  logic       model_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmos_ram_port u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .io_addr_i (io_addr),
    .io_wr_i   (io_wr),
    .io_rd_i   (io_rd),
    .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata),
    .nmi_req_i (nmi_req),
    .nmi_o     (nmi)
  );

  function automatic logic exp_nmi(logic req, logic msk);
    return req & ~msk;
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a);
    return (a == 16'h0071) ? model_ram[model_idx] : 8'hFF;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (a == 16'h0070) begin
      model_idx  = d[6:0];
      model_mask = d[7];
    end else if (a == 16'h0071) begin
      model_ram[model_idx] = d;
    end
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic check_nmi(string req, logic r);
    nmi_req = r;
    #1;
    check(req, {7'd0, nmi}, {7'd0, exp_nmi(r, model_mask)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] held;
    logic [15:0] oa;
    void'($urandom(32'd20240611));
    model_idx  = '0;
    model_mask = 1'b1;

    repeat (3) @(negedge clk);
    nmi_req = 1'b1;
    #1;
    // R1 reset state
    check("R1 nmi blocked in reset", {7'd0, nmi}, 8'h00);
    check("R1 rdata idle in reset", io_rdata, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    check_nmi("R1 nmi blocked after reset", 1'b1);

    // fill RAM, mask kept set
    for (int i = 0; i < 128; i++) begin
      io_write(16'h0070, 8'h80 | 8'(i));
      io_write(16'h0071, 8'(i * 37) ^ 8'h5A);
    end
    for (int i = 0; i < 128; i += 17) begin
      io_write(16'h0070, 8'h80 | 8'(i));
      io_read(16'h0071, rd);
      check("R4 R5 fill readback", rd, 8'(i * 37) ^ 8'h5A);
    end

    // R2 R3 mask cleared with index 5
    io_write(16'h0070, 8'h05);
    check_nmi("R3 nmi passes when mask clear", 1'b1);
    check_nmi("R3 nmi low when request low", 1'b0);
    io_read(16'h0071, rd);
    check("R2 index 5 selected", rd, model_ram[5]);
    // R9 bit 7 not part of address
    io_write(16'h0070, 8'h85);
    check_nmi("R9 index bits do not unmask", 1'b1);
    io_read(16'h0071, rd);
    check("R9 bit7 not address", rd, model_ram[5]);

    // R6 no auto-increment
    io_read(16'h0071, rd);
    check("R6 repeat read 1", rd, model_ram[5]);
    io_read(16'h0071, rd);
    check("R6 repeat read 2", rd, model_ram[5]);
    io_write(16'h0071, 8'hC3);
    io_write(16'h0071, 8'h3C);
    io_read(16'h0071, rd);
    check("R6 last write same byte", rd, 8'h3C);
    io_write(16'h0070, 8'h86);
    io_read(16'h0071, rd);
    check("R6 neighbour untouched", rd, model_ram[6]);

    // R5 hold across idle and writes
    held = rd;
    repeat (3) @(negedge clk);
    check("R5 rdata holds idle", io_rdata, held);
    io_write(16'h0071, 8'h11);
    check("R5 rdata holds across write", io_rdata, held);

    // R7 read of index port
    io_write(16'h0070, 8'h07);
    io_read(16'h0070, rd);
    check("R7 index read is FF", rd, 8'hFF);
    check_nmi("R7 mask unchanged by read", 1'b1);
    io_read(16'h0071, rd);
    check("R7 index unchanged by read", rd, model_ram[7]);

    // R8 other addresses
    io_write(16'h0072, 8'h00);
    io_write(16'h0170, 8'h80);
    io_write(16'h0000, 8'hAA);
    check_nmi("R8 mask unchanged by stray write", 1'b1);
    io_read(16'h0071, rd);
    check("R8 index and RAM unchanged", rd, model_ram[7]);
    io_read(16'h0171, rd);
    check("R8 stray read FF", rd, 8'hFF);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      case ($urandom_range(0, 5))
        0: io_write(16'h0070, 8'($urandom));
        1: io_write(16'h0071, 8'($urandom));
        2: begin
          io_read(16'h0071, rd);
          check("R5 random data read", rd, exp_read(16'h0071));
        end
        3: begin
          io_read(16'h0070, rd);
          check("R7 random index read", rd, 8'hFF);
        end
        4: begin
          oa = 16'($urandom);
          if (oa == 16'h0070 || oa == 16'h0071) oa = 16'h00F0;
          if ($urandom_range(0, 1) == 1) io_write(oa, 8'($urandom));
          else begin
            io_read(oa, rd);
            check("R8 random stray read", rd, 8'hFF);
          end
        end
        default: check_nmi("R3 random nmi gating", 1'($urandom));
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule